// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps the exclusive-access reservation of a single processor, so that a load-exclusive followed by a store-exclusive can build an atomic read-modify-write sequence. A load-exclusive opens a reservation on the aligned block that holds its address. The following store-exclusive asks the monitor for permission to write. If the reservation is still live and covers the store's block, the monitor grants the write and reports success. Otherwise it refuses the write and reports failure.

The monitor has two states, Open and Exclusive. A clear operation drops the reservation. Every store-exclusive also drops it, whatever the outcome. An ordinary store to the reserved block can either drop the reservation or leave it in place, and a parameter chooses which. Addresses are compared only at the granularity of a configurable power-of-two block. The state and the reserved tag are brought out for debug.

Top module: `excl_monitor`

## Requirements
- R1: Out of reset the monitor is Open (`mon_excl`=0), and `sx_wen` and `sx_fail` are 0.
- R2: A load-exclusive (op code 0) moves the monitor to Exclusive from either state. It also replaces the tag with the address bits at and above bit GRANULE_LOG2. `mon_tag` then shows the address with the bits below the granule zeroed.
- R3: A clear operation (op code 3) puts the monitor in Open from either state.
- R4: A store-exclusive (op code 1) always leaves the monitor Open afterwards, whatever its address and whatever the prior state.
- R5: A store-exclusive passes only when the monitor is Exclusive and the store's address tag equals the stored tag. The address bits below GRANULE_LOG2 are ignored in this compare. On a pass, `sx_wen`=1 and `sx_fail`=0 in the next cycle.
- R6: A store-exclusive that does not pass gives `sx_wen`=0 and `sx_fail`=1 in the next cycle.
- R7: `sx_wen` and `sx_fail` are registered. They reflect only a store-exclusive accepted on the previous edge and are both 0 in any other cycle.
- R8: An ordinary store (op code 2) outside the tagged block, or any store while Open, leaves the state and the tag unchanged.
- R9: An ordinary store inside the tagged block while Exclusive clears the monitor to Open when CLEAR_ON_TAGGED_STORE=1. It leaves the monitor Exclusive when CLEAR_ON_TAGGED_STORE=0.
- R10: When `op_valid` is 0, the state and the tag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_kind | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 ordinary store, 3 clear |
| op_addr | input | ADDR_W | Physical address of the operation |
| sx_wen | output | 1 | Write permission for the store-exclusive of the previous cycle |
| sx_fail | output | 1 | Status of the store-exclusive of the previous cycle: 1 failed |
| mon_excl | output | 1 | Debug: 1 when in Exclusive state |
| mon_tag | output | ADDR_W | Debug: reserved block address, low bits zero |

## Verification
The bench builds two instances side by side, each with a 32-bit address and 64-byte blocks. One has CLEAR_ON_TAGGED_STORE=1 and the other has it at 0. Both take the same stimulus. Addresses that differ only below bit 6 let the bench exercise the granule masking. Ordinary stores to the reserved block show the two selectable outcomes in the same run.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 32,
  parameter int GRANULE_LOG2 = 6,
  parameter bit CLEAR_ON_TAGGED_STORE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              sx_wen,
  output logic              sx_fail,
  output logic              mon_excl,
  output logic [ADDR_W-1:0] mon_tag
);
  localparam int TAG_W = ADDR_W - GRANULE_LOG2;
  localparam logic [1:0] OP_LDX = 2'd0, OP_STX = 2'd1, OP_ST = 2'd2, OP_CLR = 2'd3;

  logic             excl_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] op_tag;
  logic             hit, is_ldx, is_stx, is_st, is_clr;

  assign op_tag = op_addr[ADDR_W-1:GRANULE_LOG2];
  assign hit    = excl_q && (op_tag == tag_q);
  assign is_ldx = op_valid && op_kind == OP_LDX;
  assign is_stx = op_valid && op_kind == OP_STX;
  assign is_st  = op_valid && op_kind == OP_ST;
  assign is_clr = op_valid && op_kind == OP_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q  <= 1'b0;
      tag_q   <= '0;
      sx_wen  <= 1'b0;
      sx_fail <= 1'b0;
    end else begin
      sx_wen  <= is_stx && hit;
      sx_fail <= is_stx && !hit;
      if (is_ldx) begin
        excl_q <= 1'b1;
        tag_q  <= op_tag;
      end else if (is_stx || is_clr) begin
        excl_q <= 1'b0;
      end else if (is_st && hit && CLEAR_ON_TAGGED_STORE) begin
        excl_q <= 1'b0;
      end
    end
  end

  assign mon_excl = excl_q;
  assign mon_tag  = {tag_q, {GRANULE_LOG2{1'b0}}};

  a_r1_reset_open: assert property (@(posedge clk) !rst_n |=> !mon_excl && !sx_wen && !sx_fail);
  a_r2_ldx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    is_ldx |=> mon_excl && mon_tag[ADDR_W-1:GRANULE_LOG2] == $past(op_addr[ADDR_W-1:GRANULE_LOG2]));
  a_r3_clr_opens: assert property (@(posedge clk) disable iff (!rst_n) is_clr |=> !mon_excl);
  a_r4_stx_opens: assert property (@(posedge clk) disable iff (!rst_n) is_stx |=> !mon_excl);
  a_r7_status_excl: assert property (@(posedge clk) disable iff (!rst_n) !(sx_wen && sx_fail));
  a_r7_status_only_stx: assert property (@(posedge clk) disable iff (!rst_n)
    !is_stx |=> !sx_wen && !sx_fail);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(mon_excl) && $stable(mon_tag));
endmodule

// File: tb/excl_monitor_bench.sv
module excl_monitor_bench;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0, v = 0;
  logic [1:0] k = 0;
  logic [AW-1:0] a = 0;
  logic wen1, fail1, ex1, wen0, fail0, ex0;
  logic [AW-1:0] tag1, tag0;
  int checks = 0, failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRANULE_LOG2(6), .CLEAR_ON_TAGGED_STORE(1'b1)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .op_valid(v), .op_kind(k), .op_addr(a),
    .sx_wen(wen1), .sx_fail(fail1), .mon_excl(ex1), .mon_tag(tag1));
  excl_monitor #(.ADDR_W(AW), .GRANULE_LOG2(6), .CLEAR_ON_TAGGED_STORE(1'b0)) u_keep (
    .clk(clk), .rst_n(rst_n), .op_valid(v), .op_kind(k), .op_addr(a),
    .sx_wen(wen0), .sx_fail(fail0), .mon_excl(ex0), .mon_tag(tag0));

  // reference models: [0] clears on tagged store, [1] keeps
  bit m_ex[2];
  longint m_tag[2];
  bit m_wen[2], m_fail[2];
  string cur_req = "R1";

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    for (int i = 0; i < 2; i++) begin
      longint t = longint'(a) >> 6;
      bit h = m_ex[i] && (t == m_tag[i]);
      if (!rst_n) begin
        m_ex[i] = 0; m_tag[i] = 0; m_wen[i] = 0; m_fail[i] = 0;
      end else begin
        m_wen[i]  = v && k == 1 && h;
        m_fail[i] = v && k == 1 && !h;
        if (v) begin
          case (k)
            2'd0: begin m_ex[i] = 1; m_tag[i] = t; end
            2'd1, 2'd3: m_ex[i] = 0;
            2'd2: if (h && i == 0) m_ex[i] = 0;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic compare();
    chk(cur_req, "clr.excl", ex1, m_ex[0]);
    chk(cur_req, "clr.tag", tag1, m_tag[0] << 6);
    chk(cur_req, "clr.wen", wen1, m_wen[0]);
    chk(cur_req, "clr.fail", fail1, m_fail[0]);
    chk(cur_req, "keep.excl", ex0, m_ex[1]);
    chk(cur_req, "keep.tag", tag0, m_tag[1] << 6);
    chk(cur_req, "keep.wen", wen0, m_wen[1]);
    chk(cur_req, "keep.fail", fail0, m_fail[1]);
  endtask

  task automatic op(bit vv, logic [1:0] kk, logic [AW-1:0] aa, string req);
    v = vv; k = kk; a = aa;
    @(posedge clk);
    model_step();
    cur_req = req;
    #5 compare();
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    op(0, 0, 0, "R1");
    op(0, 0, 0, "R1");
    rst_n = 1;
    // R8 stores while open
    op(1, 2, 32'h1000, "R8");
    // R6 stx while open fails; R4
    op(1, 1, 32'h1000, "R6");
    op(0, 0, 0, "R7");
    // R2 ldx, granule masking
    op(1, 0, 32'h1234_5678, "R2");
    op(0, 1, 32'h0, "R10");
    op(1, 2, 32'h1234_5600, "R8");
    // R5 pass with different low bits
    op(1, 1, 32'h1234_567F, "R5");
    op(1, 1, 32'h1234_5640, "R4");
    // R6 tag mismatch
    op(1, 0, 32'h0000_0080, "R2");
    op(1, 1, 32'h0000_00C0, "R6");
    // R3 clear
    op(1, 0, 32'h0000_0080, "R2");
    op(1, 3, 32'h0, "R3");
    op(1, 1, 32'h0000_0080, "R6");
    op(1, 3, 32'h0, "R3");
    // R9 ordinary store inside tagged block
    op(1, 0, 32'hABCD_0100, "R2");
    op(1, 2, 32'hABCD_013C, "R9");
    op(1, 1, 32'hABCD_0100, "R9");
    // R2 ldx reloads while exclusive
    op(1, 0, 32'h4000_0000, "R2");
    op(1, 0, 32'h5000_0040, "R2");
    op(1, 1, 32'h5000_0041, "R5");
    for (int i = 0; i < 40; i++)
      op(i % 3 != 0, 2'((i * 7) % 4), 32'h5000_0000 + 32'(i * 24), "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    while (cyc < 5000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule